// File: doc/BRIEF.md
# Radio Channel Retune Command Sequencer

This block turns a retune request into the ordered list of register writes that move a 2.4 GHz radio front end to a new channel. A request carries a channel number (1 to 14), the index of the VCO band table found during calibration, a flag that selects the fixed autocal setup, and the transmit power integration value for the channel. From built-in tables the block works out the synthesizer word, the fractional divide ratio, the VCO band word and the transmit gain word. It then issues each one as a 24-bit command, made of a 4-bit register address and a 20-bit value, on a valid/ready stream that feeds a serial shifter placed downstream.

The request pins are plain control inputs. They are sampled on the cycle `start` is high while the block is idle. Commands leave on the `cmd_*` stream. A command is offered by holding `cmd_valid` high, and it is consumed on any rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the offered address and value stay frozen. The downstream side may hold `cmd_ready` low for any number of cycles, and the block simply waits. After the final handshake, `done` pulses for one cycle. A request that cannot be served pulses `err` for one cycle and issues no commands.

Top module: `chan_tune_seq`

## Requirements
- R1: The first command has address 1 and carries the standard synthesizer word of the channel: 0x47 for channels 1-2, 0x67 for 3-6, 0x57 for 7-10, 0x77 for 11-13 and 0x4f for 14.
- R2: When `autocal` is high, the address-1 command carries 0x6800 OR the standard synthesizer word instead (for example 0x6877 on channel 11).
- R3: The second command has address 2 and carries the divide ratio, which is the same in both modes. For channel 14 it is 0xccc. For channels 1-13 it is 0x999, 0x99b, 0x998 or 0x99a, chosen by (channel-1) mod 4 taken in that order.
- R4: The third command has address 3 and carries 0x40000 OR a 16-bit VCO word. Outside autocal, that word comes from table `vco_sel` (0 to 10) at pair index (channel-1)/2. For example, table 0 on channel 1 gives 0x664d, table 4 on channel 8 gives 0x647d, table 7 on channel 11 gives 0x6463, and table 10 on channel 14 gives 0x6673.
- R5: Under autocal, the address-3 command carries 0x46662 for every channel, and `vco_sel` is ignored.
- R6: Four address-0 commands come next, always in this order: 0x25f98, 0x25f9a, 0x25f94, 0x27fd4.
- R7: When `gain_idx` is below 19, a final address-7 command carries the gain table entry for that index. Examples are 0x00 giving 0x0e313, 0x09 giving 0x1f35b, 0x0c giving 0x1ffff and 0x12 giving 0x3ffff.
- R8: When `gain_idx` is 19 or more, the address-7 command is left out. The sequence then ends after the fourth mode write with `done`, and `err` stays low.
- R9: A channel of 0 or above 14, or a `vco_sel` of 11 or more with autocal low, raises `err` for one cycle on the cycle after the request. No command is issued.
- R10: While `cmd_valid` is high and `cmd_ready` is low, on the next cycle `cmd_valid` stays high and `cmd_addr` and `cmd_data` are unchanged.
- R11: A `start` pulse that arrives while a sequence is running is ignored. The running sequence finishes unchanged and produces exactly one `done`.
- R12: `done` pulses for one cycle, on the cycle after the last handshake, and `cmd_valid` is low during that cycle. After reset, `cmd_valid`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| chan_in | input | 4 | Requested channel, 1 to 14 |
| vco_sel | input | 4 | VCO band table index, 0 to 10 |
| autocal | input | 1 | Use fixed autocal synth and VCO words |
| gain_idx | input | 8 | Power integration value that selects the gain word |
| busy | output | 1 | A sequence is in progress |
| err | output | 1 | One-cycle pulse: request rejected |
| done | output | 1 | One-cycle pulse: sequence complete |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_addr | output | 4 | Register address of the command |
| cmd_data | output | 20 | Register value of the command |

## Verification
A corrupted step counter shows up at the ports on the very next handshake. The stream would produce a wrong address order, a missing or repeated mode write, or an extra gain write after a skip, and any of these differs from the expected list at the first affected command. A latched request that is wrong or overwritten shows up as a wrong synthesizer, divide or VCO value in the first three commands, within three handshakes of the request. A stall that lets the offered command change is seen in the cycle after the stall begins. Several channel, table and gain combinations are compared word by word, with `cmd_ready` both held high and toggled.

// File: rtl/chan_tune_pkg.sv
package chan_tune_pkg;
  localparam int CHAN_W      = 4;
  localparam int VSEL_W      = 4;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 20;
  localparam int NUM_CHAN    = 14;
  localparam int NUM_VCO_TAB = 11;
  localparam int NUM_GAIN    = 19;
  localparam int STEP_W      = 3;

  typedef enum logic [STEP_W-1:0] {
    ST_SYN    = 3'd0,
    ST_DIV    = 3'd1,
    ST_VCO    = 3'd2,
    ST_M_IDLE = 3'd3,
    ST_M_CAL  = 3'd4,
    ST_M_RUN  = 3'd5,
    ST_M_RSSI = 3'd6,
    ST_GAIN   = 3'd7
  } step_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } rf_cmd_t;

  localparam logic [DATA_W-1:0] VCO_RSV       = 20'h40000;
  localparam logic [15:0]       AUTOCAL_VCO   = 16'h6662;
  localparam logic [DATA_W-1:0] AUTOCAL_SYN   = 20'h06800;
  localparam logic [DATA_W-1:0] MODE_IDLE     = 20'h25f98;
  localparam logic [DATA_W-1:0] MODE_CAL      = 20'h25f9a;
  localparam logic [DATA_W-1:0] MODE_RUN      = 20'h25f94;
  localparam logic [DATA_W-1:0] MODE_RSSI_OFF = 20'h27fd4;
endpackage

// File: rtl/chan_tune_tables.sv
module chan_tune_tables
  import chan_tune_pkg::*;
#(
  parameter int GAIN_W = 8
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic [VSEL_W-1:0] vsel,
  input  logic              autocal,
  input  logic [GAIN_W-1:0] gidx,
  output logic [DATA_W-1:0] synth_word,
  output logic [DATA_W-1:0] div_word,
  output logic [DATA_W-1:0] vco_word,
  output logic [DATA_W-1:0] gain_word,
  output logic              gain_ok
);
  logic [CHAN_W-1:0] cm1;
  logic [2:0]        pair;
  logic [4:0]        sidx;
  logic [7:0]        std_syn;
  logic [7:0]        vlo;
  logic [7:0]        vhi;

  assign cm1  = chan - 4'd1;
  assign pair = cm1[3:1];
  // Neighbouring tables are the same low-byte series shifted by one band
  // for every two channel pairs, so one 14-entry series covers all 11 tables.
  assign sidx = {1'b0, vsel} + 5'd3 - {3'b000, pair[2:1]};

  always_comb begin
    case (chan)
      4'd1, 4'd2:                std_syn = 8'h47;
      4'd3, 4'd4, 4'd5, 4'd6:    std_syn = 8'h67;
      4'd7, 4'd8, 4'd9, 4'd10:   std_syn = 8'h57;
      4'd11, 4'd12, 4'd13:       std_syn = 8'h77;
      default:                   std_syn = 8'h4f;
    endcase
  end

  assign synth_word = autocal ? (AUTOCAL_SYN | {12'h000, std_syn})
                              : {12'h000, std_syn};

  always_comb begin
    if (chan == 4'(NUM_CHAN)) div_word = 20'h00ccc;
    else begin
      case (cm1[1:0])
        2'd0:    div_word = 20'h00999;
        2'd1:    div_word = 20'h0099b;
        2'd2:    div_word = 20'h00998;
        default: div_word = 20'h0099a;
      endcase
    end
  end

  always_comb begin
    case (sidx)
      5'd0:    vlo = 8'h65;
      5'd1:    vlo = 8'h55;
      5'd2:    vlo = 8'h75;
      5'd3:    vlo = 8'h4d;
      5'd4:    vlo = 8'h6d;
      5'd5:    vlo = 8'h5d;
      5'd6:    vlo = 8'h7d;
      5'd7:    vlo = 8'h43;
      5'd8:    vlo = 8'h63;
      5'd9:    vlo = 8'h53;
      5'd10:   vlo = 8'h73;
      5'd11:   vlo = 8'h4b;
      5'd12:   vlo = 8'h6b;
      default: vlo = 8'h5b;
    endcase
    case (pair)
      3'd1:       vhi = 8'h60;
      3'd3, 3'd5: vhi = 8'h64;
      default:    vhi = 8'h66;
    endcase
  end

  assign vco_word = VCO_RSV | {4'h0, (autocal ? AUTOCAL_VCO : {vhi, vlo})};

  assign gain_ok = (gidx < GAIN_W'(NUM_GAIN));

  always_comb begin
    case (gidx[4:0])
      5'h00: gain_word = 20'h0e313;
      5'h01: gain_word = 20'h0fb13;
      5'h02: gain_word = 20'h0e093;
      5'h03: gain_word = 20'h0f893;
      5'h04: gain_word = 20'h0ea93;
      5'h05: gain_word = 20'h1f093;
      5'h06: gain_word = 20'h1f493;
      5'h07: gain_word = 20'h1f693;
      5'h08: gain_word = 20'h1f393;
      5'h09: gain_word = 20'h1f35b;
      5'h0a: gain_word = 20'h1e6db;
      5'h0b: gain_word = 20'h1ff3f;
      5'h0c: gain_word = 20'h1ffff;
      5'h0d: gain_word = 20'h361d7;
      5'h0e: gain_word = 20'h37fbf;
      5'h0f: gain_word = 20'h3ff8b;
      5'h10: gain_word = 20'h3ff33;
      5'h11: gain_word = 20'h3fb3f;
      default: gain_word = 20'h3ffff;
    endcase
  end
endmodule

// File: rtl/chan_tune_ctrl.sv
module chan_tune_ctrl
  import chan_tune_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  req_bad,
  input  logic  gain_ok,
  input  logic  cmd_ready,
  output logic  load,
  output logic  busy,
  output logic  cmd_valid,
  output step_e step,
  output logic  done,
  output logic  err
);
  logic busy_q, done_q, err_q, last;
  step_e step_q;

  assign load = !busy_q && start && !req_bad;
  assign last = (step_q == ST_GAIN) || (step_q == ST_M_RSSI && !gain_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= ST_SYN;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (req_bad) err_q <= 1'b1;
          else begin
            busy_q <= 1'b1;
            step_q <= ST_SYN;
          end
        end
      end else if (cmd_ready) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_e'(step_q + 3'd1);
        end
      end
    end
  end

  assign busy      = busy_q;
  assign cmd_valid = busy_q;
  assign step      = step_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/chan_tune_seq.sv
module chan_tune_seq
  import chan_tune_pkg::*;
#(
  parameter int GAIN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHAN_W-1:0]    chan_in,
  input  logic [VSEL_W-1:0]    vco_sel,
  input  logic                 autocal,
  input  logic [GAIN_W-1:0]    gain_idx,
  output logic                 busy,
  output logic                 err,
  output logic                 done,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic [DATA_W-1:0]    cmd_data
);
  logic [CHAN_W-1:0] chan_q;
  logic [VSEL_W-1:0] vsel_q;
  logic              ac_q;
  logic [GAIN_W-1:0] gidx_q;
  logic              req_bad, load, gain_ok;
  logic [DATA_W-1:0] synth_w, div_w, vco_w, gain_w;
  step_e             step;
  rf_cmd_t           cmd;

  assign req_bad = (chan_in == '0) || (chan_in > CHAN_W'(NUM_CHAN)) ||
                   (!autocal && (vco_sel >= VSEL_W'(NUM_VCO_TAB)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= 4'd1;
      vsel_q <= '0;
      ac_q   <= 1'b0;
      gidx_q <= '0;
    end else if (load) begin
      chan_q <= chan_in;
      vsel_q <= vco_sel;
      ac_q   <= autocal;
      gidx_q <= gain_idx;
    end
  end

  chan_tune_tables #(.GAIN_W(GAIN_W)) u_tables (
    .chan       (chan_q),
    .vsel       (vsel_q),
    .autocal    (ac_q),
    .gidx       (gidx_q),
    .synth_word (synth_w),
    .div_word   (div_w),
    .vco_word   (vco_w),
    .gain_word  (gain_w),
    .gain_ok    (gain_ok)
  );

  chan_tune_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_bad   (req_bad),
    .gain_ok   (gain_ok),
    .cmd_ready (cmd_ready),
    .load      (load),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .step      (step),
    .done      (done),
    .err       (err)
  );

  always_comb begin
    case (step)
      ST_SYN:    cmd = '{addr: 4'd1, data: synth_w};
      ST_DIV:    cmd = '{addr: 4'd2, data: div_w};
      ST_VCO:    cmd = '{addr: 4'd3, data: vco_w};
      ST_M_IDLE: cmd = '{addr: 4'd0, data: MODE_IDLE};
      ST_M_CAL:  cmd = '{addr: 4'd0, data: MODE_CAL};
      ST_M_RUN:  cmd = '{addr: 4'd0, data: MODE_RUN};
      ST_M_RSSI: cmd = '{addr: 4'd0, data: MODE_RSSI_OFF};
      default:   cmd = '{addr: 4'd7, data: gain_w};
    endcase
  end

  assign cmd_addr = cmd.addr;
  assign cmd_data = cmd.data;
endmodule

// File: rtl/chan_tune_chk.sv
module chan_tune_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        err,
  input logic        done,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [3:0]  cmd_addr,
  input logic [19:0] cmd_data
);
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> (cmd_addr == 4'd1));

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cmd_valid && !done));

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !busy));

  a_r6_mode_follows_vco: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_addr == 4'd3) |=>
      (cmd_valid && cmd_addr == 4'd0 && cmd_data == 20'h25f98));

  a_r4_vco_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == 4'd3) |-> (cmd_data[19:16] == 4'h4));

  a_r12_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && cmd_ready));
endmodule

bind chan_tune_seq chan_tune_chk u_chan_tune_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .err       (err),
  .done      (done),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data)
);

// File: tb/test_chan_tune_seq.sv
module test_chan_tune_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  chan_in = 4'd1;
  logic [3:0]  vco_sel = 4'd0;
  logic        autocal = 1'b0;
  logic [7:0]  gain_idx = 8'd0;
  logic        busy, err, done, cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [3:0]  cmd_addr;
  logic [19:0] cmd_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int ready_mode = 0;
  int ncap = 0;
  int n_done = 0;
  int n_err = 0;
  int hold_bad = 0;
  logic [3:0]  cap_addr [0:15];
  logic [19:0] cap_data [0:15];
  logic        prev_stall = 1'b0;
  logic [3:0]  prev_addr = '0;
  logic [19:0] prev_data = '0;

  chan_tune_seq i_chan_tune_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_in(chan_in),
    .vco_sel(vco_sel), .autocal(autocal), .gain_idx(gain_idx),
    .busy(busy), .err(err), .done(done), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prev_stall && (!cmd_valid || cmd_addr != prev_addr || cmd_data != prev_data))
      hold_bad++;
    if (ready_mode == 0) cmd_ready = 1'b1;
    else cmd_ready = (cyc[0] ^ cyc[2]);
    if (cmd_valid && cmd_ready && ncap < 16) begin
      cap_addr[ncap] = cmd_addr;
      cap_data[ncap] = cmd_data;
      ncap++;
    end
    prev_stall = cmd_valid && !cmd_ready;
    prev_addr  = cmd_addr;
    prev_data  = cmd_data;
    if (done) n_done++;
    if (err)  n_err++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end (actual cycles %0d, expected < %0d)", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [3:0] ch, input logic [3:0] vs,
                             input logic ac, input logic [7:0] g);
    @(negedge clk);
    chan_in = ch; vco_sel = vs; autocal = ac; gain_idx = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input int d0, input int e0);
    for (int i = 0; i < 200; i++) begin
      if (n_done != d0 || n_err != e0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // One retune request, compared against an independent expected list.
  task automatic run_seq(input string req, input logic [3:0] ch, input logic [3:0] vs,
                         input logic ac, input logic [7:0] g, input int mode,
                         input logic [19:0] e_syn, input logic [19:0] e_div,
                         input logic [19:0] e_vco, input logic has_g,
                         input logic [19:0] e_gain, input logic inject);
    logic [3:0]  ea [0:7];
    logic [19:0] ed [0:7];
    int n, d0, e0;
    ea[0] = 4'd1; ed[0] = e_syn;
    ea[1] = 4'd2; ed[1] = e_div;
    ea[2] = 4'd3; ed[2] = e_vco;
    ea[3] = 4'd0; ed[3] = 20'h25f98;
    ea[4] = 4'd0; ed[4] = 20'h25f9a;
    ea[5] = 4'd0; ed[5] = 20'h25f94;
    ea[6] = 4'd0; ed[6] = 20'h27fd4;
    ea[7] = 4'd7; ed[7] = e_gain;
    n = has_g ? 8 : 7;
    ready_mode = mode;
    ncap = 0; hold_bad = 0;
    d0 = n_done; e0 = n_err;
    pulse_start(ch, vs, ac, g);
    if (inject) begin
      repeat (2) @(negedge clk);
      check({req, " R11 busy during run"}, 32'(busy), 32'd1);
      pulse_start(4'd14, 4'd10, 1'b0, 8'd0);
    end
    wait_end(d0, e0);
    check({req, " R12 one done"}, 32'(n_done - d0), 32'd1);
    check({req, " R9 no err"}, 32'(n_err - e0), 32'd0);
    check({req, " R8 command count"}, 32'(ncap), 32'(n));
    for (int k = 0; k < n && k < ncap; k++) begin
      check({req, " addr"}, 32'(cap_addr[k]), 32'(ea[k]));
      check({req, " data"}, 32'(cap_data[k]), 32'(ed[k]));
    end
    check({req, " R10 held under stall"}, 32'(hold_bad), 32'd0);
    repeat (4) @(negedge clk);
    check({req, " R11 idle after"}, 32'(busy), 32'd0);
    ready_mode = 0;
  endtask

  task automatic run_bad(input string req, input logic [3:0] ch,
                         input logic [3:0] vs, input logic ac);
    int d0, e0;
    ncap = 0; d0 = n_done; e0 = n_err;
    pulse_start(ch, vs, ac, 8'd0);
    repeat (6) @(negedge clk);
    check({req, " R9 err pulse"}, 32'(n_err - e0), 32'd1);
    check({req, " R9 no commands"}, 32'(ncap), 32'd0);
    check({req, " R9 no done"}, 32'(n_done - d0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset cmd_valid", 32'(cmd_valid), 32'd0);
    check("R12 reset busy", 32'(busy), 32'd0);
    check("R12 reset done", 32'(done), 32'd0);
    check("R12 reset err", 32'(err), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R4 R6 R7: channel 1, table 0, gain 0x00
    run_seq("R1 ch1 t0", 4'd1, 4'd0, 1'b0, 8'h00, 0,
            20'h00047, 20'h00999, 20'h4664d, 1'b1, 20'h0e313, 1'b0);
    // R1 R3 R4 R7: channel 14, table 10, gain 0x12
    run_seq("R4 ch14 t10", 4'd14, 4'd10, 1'b0, 8'h12, 0,
            20'h0004f, 20'h00ccc, 20'h46673, 1'b1, 20'h3ffff, 1'b0);
    // R4 R7 R10: channel 8, table 4, gain 0x09, toggling ready
    run_seq("R10 ch8 t4 stall", 4'd8, 4'd4, 1'b0, 8'h09, 1,
            20'h00057, 20'h0099a, 20'h4647d, 1'b1, 20'h1f35b, 1'b0);
    // R2 R5 R8: autocal on channel 11, out-of-range table ignored, gain 19 skipped
    run_seq("R2 R5 R8 ch11 autocal", 4'd11, 4'd15, 1'b1, 8'd19, 0,
            20'h06877, 20'h00998, 20'h46662, 1'b0, 20'h0, 1'b0);
    // R2 R5 R7 R11: autocal channel 5, gain 0x0c, second start while busy
    run_seq("R11 ch5 autocal inject", 4'd5, 4'd3, 1'b1, 8'h0c, 1,
            20'h06867, 20'h00999, 20'h46662, 1'b1, 20'h1ffff, 1'b1);
    // R4 R8: channel 11, table 7, gain 0xff skipped
    run_seq("R8 ch11 t7 gain ff", 4'd11, 4'd7, 1'b0, 8'hff, 1,
            20'h00077, 20'h00998, 20'h46463, 1'b0, 20'h0, 1'b0);

    run_bad("R9 chan 0", 4'd0, 4'd0, 1'b0);
    run_bad("R9 chan 15", 4'd15, 4'd0, 1'b0);
    run_bad("R9 table 11", 4'd3, 4'd11, 1'b0);

    summary();
  end
endmodule